// File: doc/BRIEF.md
# Write-Gated Register Bank

This block holds a lock register and six 8-bit data registers behind a plain CPU port. The port has an address, a write strobe with write data, and a read strobe with registered read data. Every data register decides on its own whether to accept a write. For two of them the decision comes from dedicated input pins, one active high and one active low. For the other four it comes from bits of the lock register, which sits in the same bank and can always be written.

Two lock bits steer four registers. Bit 0 enables addresses 3 and 5 when it is set. Bit 1 is shared by addresses 4 and 6 with opposite sense: while the bit is clear only address 4 can be written, and while it is set only address 6 can be written. Reads are never gated. Software can therefore always see what a refused write left behind.

Top module: `wgate_regbank`

## Requirements
- R1: Synchronous active-high reset sets the lock register to 0x01 and data registers 1..6 to 0x11, 0x22, 0x33, 0x44, 0x55, 0x66. It also clears the read data to 0.
- R2: A write to address 0 is always accepted. It stores bits [1:0] of the write data, and bits [7:2] of address 0 always read as 0.
- R3: Address 1 accepts a write only while `ext_wr_ok` is 1. Otherwise its value is unchanged.
- R4: Address 2 accepts a write only while `ext_wr_ok_n` is 0. Otherwise its value is unchanged.
- R5: Addresses 3 and 5 accept a write only while lock bit 0 is 1. Otherwise their values are unchanged.
- R6: Address 4 accepts a write only while lock bit 1 is 0. Otherwise its value is unchanged.
- R7: Address 6 accepts a write only while lock bit 1 is 1. Otherwise its value is unchanged.
- R8: When `rd_en` is high at a clock edge, `rd_data` takes the value at `addr` after that edge. Address 7 reads as 0. `rd_data` holds its value while `rd_en` is low.
- R9: A write to address 7 changes no register.
- R10: The enable is sampled in the cycle of the write strobe. A lock write governs a data write in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| ext_wr_ok | input | 1 | Active-high write enable for address 1 |
| ext_wr_ok_n | input | 1 | Active-low write enable for address 2 |

## Verification
The main corner case is the shared lock bit 1. A design that gave address 6 the same polarity as address 4 would let both registers be written together, or refuse both. The bench issues a lock write and a data write back to back. A design that sampled the enable one cycle late, or that forwarded the new lock value early, would store or drop the wrong value. The bench also writes to the unmapped address and reads it back, and checks that the upper lock bits read as zero, to catch stray decode and storage.

// File: rtl/wgate_regbank.sv
module wgate_regbank #(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int NREG = 6,
  parameter int LW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          ext_wr_ok,
  input  logic          ext_wr_ok_n
);

  localparam logic [LW-1:0] LOCK_INIT = LW'(1);

  logic [LW-1:0]          lock_q;
  logic [NREG:1][DW-1:0]  data_q;
  logic [NREG:1]          allow;
  logic [DW-1:0]          rd_mux;

  assign allow[1] = ext_wr_ok;
  assign allow[2] = ~ext_wr_ok_n;
  assign allow[3] = lock_q[0];
  assign allow[4] = ~lock_q[1];
  assign allow[5] = lock_q[0];
  assign allow[6] = lock_q[1];

  always_ff @(posedge clk) begin
    if (rst)
      lock_q <= LOCK_INIT;
    else if (wr_en && addr == '0)
      lock_q <= wr_data[LW-1:0];
  end

  for (genvar i = 1; i <= NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        data_q[i] <= DW'(i * 17);
      else if (wr_en && addr == AW'(i) && allow[i])
        data_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == '0) rd_mux = DW'(lock_q);
    for (int i = 1; i <= NREG; i++)
      if (addr == AW'(i)) rd_mux = data_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_mux;
  end

  // R3
  r1_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(1) && !ext_wr_ok) |=> $stable(data_q[1]));
  // R4
  r2_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(2) && ext_wr_ok_n) |=> $stable(data_q[2]));
  // R5
  r3_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(3) && !lock_q[0]) |=> $stable(data_q[3]));
  // R5
  r5_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(5) && !lock_q[0]) |=> $stable(data_q[5]));
  // R6
  r4_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(4) && lock_q[1]) |=> $stable(data_q[4]));
  // R7
  r6_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(6) && !lock_q[1]) |=> $stable(data_q[6]));
  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(7)) |=> (rd_data == '0));
  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/test_wgate_regbank.sv
module test_wgate_regbank;
  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] addr = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       rd_en = 0;
  logic [7:0] rd_data;
  logic       ext_wr_ok = 0;
  logic       ext_wr_ok_n = 1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wgate_regbank i_wgate_regbank (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ext_wr_ok(ext_wr_ok), .ext_wr_ok_n(ext_wr_ok_n));

  // {req[3:0], write, addr[2:0], data[7:0], ext_wr_ok, ext_wr_ok_n, expect[7:0]}
  localparam int NV = 42;
  localparam logic [25:0] TBL [NV] = '{
    {4'd1,1'b0,3'd1,8'h00,1'b0,1'b1,8'h11},  // R1
    {4'd3,1'b1,3'd1,8'h12,1'b0,1'b1,8'h00},  // R3
    {4'd3,1'b0,3'd1,8'h00,1'b0,1'b1,8'h11},
    {4'd3,1'b1,3'd1,8'h13,1'b1,1'b1,8'h00},
    {4'd3,1'b0,3'd1,8'h00,1'b0,1'b1,8'h13},
    {4'd4,1'b0,3'd2,8'h00,1'b0,1'b1,8'h22},  // R4
    {4'd4,1'b1,3'd2,8'h23,1'b0,1'b1,8'h00},
    {4'd4,1'b0,3'd2,8'h00,1'b0,1'b1,8'h22},
    {4'd4,1'b1,3'd2,8'h24,1'b0,1'b0,8'h00},
    {4'd4,1'b0,3'd2,8'h00,1'b0,1'b1,8'h24},
    {4'd5,1'b0,3'd3,8'h00,1'b0,1'b1,8'h33},  // R5
    {4'd5,1'b1,3'd0,8'h00,1'b0,1'b1,8'h00},
    {4'd5,1'b1,3'd3,8'h32,1'b0,1'b1,8'h00},
    {4'd5,1'b0,3'd3,8'h00,1'b0,1'b1,8'h33},
    {4'd5,1'b1,3'd0,8'h01,1'b0,1'b1,8'h00},
    {4'd5,1'b1,3'd3,8'h34,1'b0,1'b1,8'h00},
    {4'd5,1'b0,3'd3,8'h00,1'b0,1'b1,8'h34},
    {4'd5,1'b1,3'd0,8'h00,1'b0,1'b1,8'h00},
    {4'd5,1'b1,3'd5,8'h52,1'b0,1'b1,8'h00},
    {4'd5,1'b0,3'd5,8'h00,1'b0,1'b1,8'h55},
    {4'd5,1'b1,3'd0,8'h01,1'b0,1'b1,8'h00},
    {4'd5,1'b1,3'd5,8'h54,1'b0,1'b1,8'h00},
    {4'd5,1'b0,3'd5,8'h00,1'b0,1'b1,8'h54},
    {4'd6,1'b0,3'd4,8'h00,1'b0,1'b1,8'h44},  // R6
    {4'd6,1'b1,3'd0,8'h02,1'b0,1'b1,8'h00},
    {4'd6,1'b1,3'd4,8'h40,1'b0,1'b1,8'h00},
    {4'd6,1'b0,3'd4,8'h00,1'b0,1'b1,8'h44},
    {4'd6,1'b1,3'd0,8'h00,1'b0,1'b1,8'h00},
    {4'd6,1'b1,3'd4,8'h45,1'b0,1'b1,8'h00},
    {4'd6,1'b0,3'd4,8'h00,1'b0,1'b1,8'h45},
    {4'd7,1'b1,3'd6,8'h60,1'b0,1'b1,8'h00},  // R7
    {4'd7,1'b0,3'd6,8'h00,1'b0,1'b1,8'h66},
    {4'd7,1'b1,3'd0,8'h02,1'b0,1'b1,8'h00},
    {4'd7,1'b1,3'd6,8'h65,1'b0,1'b1,8'h00},
    {4'd7,1'b0,3'd6,8'h00,1'b0,1'b1,8'h65},
    {4'd2,1'b0,3'd0,8'h00,1'b0,1'b1,8'h02},  // R2
    {4'd2,1'b1,3'd0,8'hFF,1'b0,1'b1,8'h00},
    {4'd2,1'b0,3'd0,8'h00,1'b0,1'b1,8'h03},
    {4'd9,1'b1,3'd7,8'hAA,1'b1,1'b0,8'h00},  // R9
    {4'd8,1'b0,3'd7,8'h00,1'b0,1'b1,8'h00},  // R8
    {4'd9,1'b0,3'd1,8'h13,1'b0,1'b1,8'h13},
    {4'd9,1'b0,3'd6,8'h00,1'b0,1'b1,8'h65}
  };

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check(1, rd_data, 8'h00);  // R1 read data cleared
    rst = 0;
    for (int i = 0; i < NV; i++) begin
      ext_wr_ok = TBL[i][9]; ext_wr_ok_n = TBL[i][8];
      if (TBL[i][21]) wr(TBL[i][20:18], TBL[i][17:10]);
      else begin
        rd(TBL[i][20:18], v);
        check(int'(TBL[i][25:22]), v, TBL[i][7:0]);
      end
    end
    ext_wr_ok = 0; ext_wr_ok_n = 1;
    // R10: lock write then data write on the next cycle
    wr(3'd0, 8'h00);
    @(negedge clk); addr = 0; wr_data = 8'h01; wr_en = 1;
    @(negedge clk); addr = 3; wr_data = 8'h77;
    @(negedge clk); wr_en = 0;
    rd(3'd3, v); check(10, v, 8'h77);
    @(negedge clk); addr = 0; wr_data = 8'h00; wr_en = 1;
    @(negedge clk); addr = 3; wr_data = 8'h88;
    @(negedge clk); wr_en = 0;
    rd(3'd3, v); check(10, v, 8'h77);
    // R8: read data holds while rd_en is low
    addr = 3'd4;
    repeat (3) @(negedge clk);
    check(8, rd_data, 8'h77);
    // R1: reset mid-run restores values
    rst = 1; @(negedge clk); rst = 0;
    rd(3'd4, v); check(1, v, 8'h44);
    rd(3'd0, v); check(1, v, 8'h01);
    rd(3'd6, v); check(1, v, 8'h66);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule